// File: doc/BRIEF.md
# Small Register File with Chip Select

This block is a tiny synchronous storage array of sixteen 4-bit words. One address port serves both reading and writing. An active-low chip select and an active-low write enable together pick one of three modes: disabled, read or write. A write commits on the rising clock edge of any cycle in which both controls are low. The stored word goes to the addressed location.

The output port carries data only in read mode. In read mode it shows the addressed word through a purely combinational path. In write mode, and whenever the chip is deselected, the output is driven to all zeros. Several copies can therefore share an OR-combined data bus for depth expansion, with the chip selects picking the active one.

The write can be framed by either control. If chip select is held low, a write-enable pulse sets the write window. If write enable is held low, a chip-select pulse sets it. An active-low reset blocks writes and quiets the output, but it does not clear the array.

Top module: `nib_regfile`

## Requirements
- R1: With default parameters the array holds 16 independent 4-bit words, selected by a 4-bit address. Writing one word leaves every other word unchanged.
- R2: While `cs_n` is 1, `dout` is all zeros, whatever the values of `we_n`, `addr` and the stored contents.
- R3: A cycle with `cs_n` at 1 and `we_n` at 0 does not change any stored word.
- R4: When `cs_n` and `we_n` are both 0 at a rising edge of `clk` (with `rst_n` at 1), `din` is stored at the word selected by `addr`.
- R5: While `cs_n` and `we_n` are both 0, `dout` is all zeros.
- R6: While `cs_n` is 0 and `we_n` is 1, `dout` equals the word at `addr`, in the same cycle that `addr` is presented.
- R7: A word written at one edge is visible on the first read cycle that follows. Of back-to-back writes to one address, the last one wins.
- R8: With `we_n` held at 0, a single-cycle low pulse on `cs_n` commits exactly one write. Changes to `din` after `cs_n` returns high are not stored.
- R9: While `rst_n` is 0, no write occurs and `dout` is all zeros. Reset does not clear stored words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes and quiets the output |
| cs_n | input | 1 | Active-low chip select |
| we_n | input | 1 | Active-low write enable |
| addr | input | ADDR_W (4) | Word address |
| din | input | DATA_W (4) | Write data |
| dout | output | DATA_W (4) | Read data, zero unless in read mode |

## Verification
Some properties are checked on every cycle: the output stays quiet while deselected, while writing and while in reset. A read repeated at an unchanged address returns an unchanged value. A read right after a write to the same address returns the written data. A read taken across a deselected write cycle is unchanged. Other behaviour shows only in the bench's scenarios: that every address is an independent word, that a chip-select-strobed write stores the data present at the strobe and not what follows, and that contents survive a reset pulse.

// File: rtl/nrf_pkg.sv
package nrf_pkg;

   typedef enum logic [1:0] {
      NRF_OFF   = 2'b00,
      NRF_READ  = 2'b01,
      NRF_WRITE = 2'b10
   } nrf_mode_e;

   function automatic nrf_mode_e nrf_mode_of(input logic rst_n,
                                             input logic cs_n,
                                             input logic we_n);
      if (!rst_n || cs_n) return NRF_OFF;
      if (we_n)           return NRF_READ;
      return NRF_WRITE;
   endfunction

endpackage

// File: rtl/nrf_ctrl.sv
module nrf_ctrl
   import nrf_pkg::*;
(
   input  logic rst_n,
   input  logic cs_n,
   input  logic we_n,
   output logic wr_en,
   output logic rd_en
);
   nrf_mode_e mode;

   always_comb begin
      mode  = nrf_mode_of(rst_n, cs_n, we_n);
      wr_en = (mode == NRF_WRITE);
      rd_en = (mode == NRF_READ);
   end
endmodule

// File: rtl/nrf_decode.sv
module nrf_decode #(
   parameter int ADDR_W = 4,
   localparam int WORDS = 1 << ADDR_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [WORDS-1:0]  sel
);
   for (genvar i = 0; i < WORDS; i++) begin : g_sel
      assign sel[i] = (addr == ADDR_W'(i));
   end
endmodule

// File: rtl/nrf_store.sv
module nrf_store #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 4,
   localparam int WORDS = 1 << ADDR_W
) (
   input  logic                         clk,
   input  logic                         wr_en,
   input  logic [WORDS-1:0]             sel,
   input  logic [DATA_W-1:0]            din,
   output logic [WORDS-1:0][DATA_W-1:0] words
);
   for (genvar i = 0; i < WORDS; i++) begin : g_word
      always_ff @(posedge clk) begin
         if (wr_en && sel[i]) words[i] <= din;
      end
   end
endmodule

// File: rtl/nrf_rdpath.sv
module nrf_rdpath #(
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 4,
   parameter bit ONEHOT_MUX = 1'b1,
   localparam int WORDS = 1 << ADDR_W
) (
   input  logic                         rd_en,
   input  logic [ADDR_W-1:0]            addr,
   input  logic [WORDS-1:0][DATA_W-1:0] words,
   output logic [DATA_W-1:0]            dout
);
   logic [DATA_W-1:0] picked;

   if (ONEHOT_MUX) begin : g_andor
      logic [WORDS-1:0] rsel;
      nrf_decode #(.ADDR_W(ADDR_W)) u_rdec (.addr(addr), .sel(rsel));
      always_comb begin
         picked = '0;
         for (int i = 0; i < WORDS; i++) begin
            picked = picked | ({DATA_W{rsel[i]}} & words[i]);
         end
      end
   end else begin : g_index
      assign picked = words[addr];
   end

   assign dout = rd_en ? picked : '0;
endmodule

// File: rtl/nib_regfile.sv
module nib_regfile #(
   parameter int ADDR_W     = 4,
   parameter int DATA_W     = 4,
   parameter bit ONEHOT_MUX = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int WORDS = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("nib_regfile: ADDR_W must lie in 1..10");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("nib_regfile: DATA_W must be at least 1");
   end

   logic                         wr_en;
   logic                         rd_en;
   logic [WORDS-1:0]             wsel;
   logic [WORDS-1:0][DATA_W-1:0] words;

   nrf_ctrl u_ctrl (
      .rst_n (rst_n),
      .cs_n  (cs_n),
      .we_n  (we_n),
      .wr_en (wr_en),
      .rd_en (rd_en)
   );

   nrf_decode #(.ADDR_W(ADDR_W)) u_wdec (
      .addr (addr),
      .sel  (wsel)
   );

   nrf_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk   (clk),
      .wr_en (wr_en),
      .sel   (wsel),
      .din   (din),
      .words (words)
   );

   nrf_rdpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ONEHOT_MUX(ONEHOT_MUX)) u_rd (
      .rd_en (rd_en),
      .addr  (addr),
      .words (words),
      .dout  (dout)
   );
endmodule

// File: rtl/nib_regfile_chk.sv
module nib_regfile_chk #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              we_n,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] din,
   input logic [DATA_W-1:0] dout
);
   logic wr;
   logic rd;
   assign wr = rst_n && !cs_n && !we_n;
   assign rd = rst_n && !cs_n && we_n;

   // R2: deselected output is quiet
   assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> dout == '0);

   // R5: output is quiet during a write
   assert_write_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !we_n) |-> dout == '0);

   // R6: repeated read of the same address is stable
   assert_read_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && $past(rd) && addr == $past(addr)) |-> dout == $past(dout));

   // R7: read right after a write to the same address returns that data
   assert_wr_then_rd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (!(rd && addr == $past(addr)) || dout == $past(din)));

   // R3: a deselected cycle between two reads of one address changes nothing
   assert_off_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && $past(cs_n) && $past(rd, 2) && addr == $past(addr, 2))
         |-> dout == $past(dout, 2));

   // R9: output is quiet while in reset
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_quiet_R9: assert (dout == '0);
      end
   end
endmodule

bind nib_regfile nib_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cs_n  (cs_n),
   .we_n  (we_n),
   .addr  (addr),
   .din   (din),
   .dout  (dout)
);

// File: tb/nib_regfile_test.sv
module nib_regfile_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       we_n = 1'b1;
   logic [3:0] addr = '0;
   logic [3:0] din = '0;
   logic [3:0] dout;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   nib_regfile uut (
      .clk   (clk),
      .rst_n (rst_n),
      .cs_n  (cs_n),
      .we_n  (we_n),
      .addr  (addr),
      .din   (din),
      .dout  (dout)
   );

   always #4 clk = ~clk;

   // fields: cs_n, we_n, addr, din, expected dout
   localparam logic [13:0] VEC [16] = '{
      {1'b0, 1'b0, 4'h3, 4'h5, 4'h0},  // write
      {1'b0, 1'b1, 4'h3, 4'h0, 4'h5},  // read back
      {1'b0, 1'b0, 4'h3, 4'hA, 4'h0},  // back-to-back writes
      {1'b0, 1'b0, 4'h3, 4'hC, 4'h0},
      {1'b0, 1'b1, 4'h3, 4'h0, 4'hC},  // last one wins
      {1'b1, 1'b0, 4'h3, 4'h1, 4'h0},  // deselected write
      {1'b0, 1'b1, 4'h3, 4'h0, 4'hC},  // ignored
      {1'b1, 1'b1, 4'h3, 4'h0, 4'h0},  // deselected read
      {1'b0, 1'b0, 4'h0, 4'hF, 4'h0},
      {1'b0, 1'b0, 4'hF, 4'h6, 4'h0},
      {1'b0, 1'b1, 4'h0, 4'h0, 4'hF},
      {1'b0, 1'b1, 4'hF, 4'h0, 4'h6},
      {1'b0, 1'b0, 4'h7, 4'h9, 4'h0},
      {1'b0, 1'b1, 4'h7, 4'h0, 4'h9},
      {1'b0, 1'b1, 4'h3, 4'h0, 4'hC},
      {1'b1, 1'b1, 4'hF, 4'h0, 4'h0}
   };

   task automatic report();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // drive at the falling edge, settle, then the next rising edge commits
   task automatic drive(input logic c, input logic w, input logic [3:0] a, input logic [3:0] d);
      @(negedge clk);
      cs_n = c;
      we_n = w;
      addr = a;
      din  = d;
      #1;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
         report();
      end
   end

   initial begin
      // reset state: read mode requested while in reset
      drive(1'b0, 1'b1, 4'h0, 4'h0);
      check("R9 reset read quiet", dout, 4'h0);
      drive(1'b0, 1'b0, 4'h2, 4'h7);
      check("R9 reset write quiet", dout, 4'h0);
      drive(1'b1, 1'b1, 4'h0, 4'h0);
      rst_n = 1'b1;

      // vector table: R4 R5 R6 R7 R2 R3
      for (int i = 0; i < 16; i++) begin
         drive(VEC[i][13], VEC[i][12], VEC[i][11:8], VEC[i][7:4]);
         check($sformatf("table %0d R2 R3 R4 R5 R6 R7", i), dout, VEC[i][3:0]);
      end

      // R9: write attempt during reset is blocked, contents survive
      drive(1'b1, 1'b1, 4'h3, 4'h0);
      rst_n = 1'b0;
      drive(1'b0, 1'b0, 4'h3, 4'h2);
      check("R9 reset quiet mid-run", dout, 4'h0);
      drive(1'b1, 1'b1, 4'h3, 4'h0);
      rst_n = 1'b1;
      drive(1'b0, 1'b1, 4'h3, 4'h0);
      check("R9 contents kept", dout, 4'hC);

      // R8: chip-select strobe with write enable held low
      drive(1'b1, 1'b0, 4'h5, 4'hA);
      check("R2 deselected with we low", dout, 4'h0);
      drive(1'b0, 1'b0, 4'h5, 4'hA);
      check("R5 strobe window quiet", dout, 4'h0);
      drive(1'b1, 1'b0, 4'h5, 4'h3);
      drive(1'b0, 1'b1, 4'h5, 4'h0);
      check("R8 cs strobed write", dout, 4'hA);

      // R6: address change shows new word in the same cycle
      drive(1'b0, 1'b1, 4'h7, 4'h0);
      check("R6 same-cycle address change", dout, 4'h9);

      // R1: every address is an independent word
      for (int a = 0; a < 16; a++) begin
         drive(1'b0, 1'b0, 4'(a), 4'((a * 7 + 3) & 15));
      end
      for (int a = 0; a < 16; a++) begin
         drive(1'b0, 1'b1, 4'(a), 4'h0);
         check($sformatf("R1 sweep addr %0d", a), dout, 4'((a * 7 + 3) & 15));
      end
      drive(1'b1, 1'b1, 4'h0, 4'h0);
      check("R2 idle", dout, 4'h0);

      done = 1'b1;
      report();
   end
endmodule